// File: doc/BRIEF.md
# Continuation-Record Fibonacci Evaluator

This block evaluates fib(n) by the doubly recursive rule, with fib(1) = fib(2) = 1 and fib(n) = fib(n-1) + fib(n-2) above that. No hardware call stack is used. Each suspended step is a continuation record in a private record memory, and a small state machine moves between two activities. In the first, it evaluates a number under a pointer to its continuation. In the second, it applies a loaded continuation to a computed value. The three record kinds are a terminal record, a pending record that holds n and a link, and a partial-sum record that holds a value and a link. Records are handed out by a bump pointer, which restarts with every new request.

A request enters on a valid/ready stream that carries n. The result leaves on a valid/ready stream that carries the value and an error flag. Only one request is in flight at a time. `req_ready` is high only while the engine is idle, so a producer holding `req_valid` just waits. A result is presented with `rsp_valid` and stays unchanged until the consumer raises `rsp_ready`. No new request is taken until that result has been consumed. The largest n the engine accepts, `MAX_N`, comes from the record memory depth and the data width.

Top module: `fib_cont_engine`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From that edge until its result is consumed, `req_ready` is 0. Any `req_valid` or `req_n` activity in that window does not change the result.
- R3: For n = 1 and n = 2 the result is 1, with `rsp_err` = 0.
- R4: For 3 <= n <= MAX_N the result is fib(n-1) + fib(n-2), with `rsp_err` = 0.
- R5: A request with n = 0 or n > MAX_N is rejected. One cycle after it is taken, `rsp_valid` is 1, `rsp_err` is 1 and `rsp_value` is 0.
- R6: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_value` and `rsp_err` hold their values. The result is consumed on the edge where both are 1.
- R7: A record is {tag[1:0], value[DATA_W-1:0], link[AW-1:0]}, with tag 0 = terminal, 1 = pending and 2 = partial sum. The terminal record sits at index 0. The bump pointer restarts at 1 on every accepted request and increases by one per stored record. Every load reads an index that has been stored since the current request was taken, so back-to-back requests give correct results.
- R8: MAX_N is the largest n for which 2*fib(n)-1 < DEPTH and fib(n) < 2^DATA_W. With the defaults (DEPTH 256, DATA_W 16) MAX_N is 11, so n = 11 is computed and n = 12 is rejected.
- R9: Record memory reads return data one cycle after they are issued, and no cycle issues both a store and a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready (high only when idle) |
| req_n | input | DATA_W | Argument n |
| rsp_valid | output | 1 | Result stream valid |
| rsp_ready | input | 1 | Result stream ready |
| rsp_value | output | DATA_W | fib(n), or 0 on error |
| rsp_err | output | 1 | 1 when the request was rejected |

## Verification
The assertions check the following on every cycle:
- a held result does not change under back-pressure;
- a rejected n produces an error response in the very next cycle;
- loads reach only records stored since the current start;
- the bump pointer advances one step per store;
- store and load are never issued together.

Only the bench scenarios can show that the arithmetic is right across the whole range of n. The same goes for the MAX_N boundary, for requests offered while the engine is busy being ignored, and for a second run after a large one still reading fresh records.

// File: rtl/fib_pkg.sv
package fib_pkg;

  typedef enum logic [1:0] {
    K_TERM = 2'd0,
    K_PEND = 2'd1,
    K_SUM  = 2'd2
  } cont_tag_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVAL  = 2'd1,
    ST_APPLY = 2'd2,
    ST_RESP  = 2'd3
  } eng_state_e;

  // Largest n whose full evaluation fits the record store and the data width.
  function automatic int max_n_for(input int depth, input int data_w);
    longint f_prev;
    longint f_cur;
    longint f_nxt;
    longint lim;
    int     best;
    f_prev = 0;
    f_cur  = 1;
    best   = 0;
    lim    = longint'(1) << data_w;
    for (int k = 1; k < 60; k++) begin
      if ((2 * f_cur - 1) < longint'(depth) && f_cur < lim && best == k - 1)
        best = k;
      f_nxt  = f_cur + f_prev;
      f_prev = f_cur;
      f_cur  = f_nxt;
    end
    return best;
  endfunction

endpackage

// File: rtl/fib_rec_store.sv
module fib_rec_store #(
  parameter int REC_W = 26,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [REC_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [REC_W-1:0] rd_data
);
  logic [REC_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
    if (rd_en) rd_data <= cells[rd_addr];
  end

  // R9: a single port action per cycle
  assert_one_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, rd_en}));

endmodule

// File: rtl/fib_bump_alloc.sv
module fib_bump_alloc #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          bump,
  output logic [AW-1:0] next_idx
);
  always_ff @(posedge clk) begin
    if (!rst_n)       next_idx <= AW'(1);
    else if (restart) next_idx <= AW'(1);
    else if (bump)    next_idx <= next_idx + AW'(1);
  end

  assert_alloc_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({restart, bump}));

  assert_alloc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bump |=> next_idx == $past(next_idx) + AW'(1));

endmodule

// File: rtl/fib_ctrl.sv
module fib_ctrl
  import fib_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  parameter int MAX_N  = 11,
  localparam int AW    = $clog2(DEPTH),
  localparam int REC_W = 2 + DATA_W + AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_n,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_value,
  output logic              rsp_err,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [REC_W-1:0]  wr_data,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  input  logic [REC_W-1:0]  rd_data,
  output logic              alloc_restart,
  output logic              alloc_bump,
  input  logic [AW-1:0]     alloc_idx
);
  eng_state_e        state;
  logic [DATA_W-1:0] cur_n;
  logic [AW-1:0]     cur_k;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] res_q;
  logic              err_q;

  cont_tag_e         ld_tag;
  logic [DATA_W-1:0] ld_val;
  logic [AW-1:0]     ld_link;
  logic              n_ok;
  logic              leaf;

  assign ld_tag  = cont_tag_e'(rd_data[REC_W-1 -: 2]);
  assign ld_val  = rd_data[AW +: DATA_W];
  assign ld_link = rd_data[AW-1:0];
  assign n_ok    = (req_n != '0) && (req_n <= DATA_W'(MAX_N));
  assign leaf    = (cur_n <= DATA_W'(2));

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_value = res_q;
  assign rsp_err   = err_q;

  always_comb begin
    wr_en         = 1'b0;
    wr_addr       = '0;
    wr_data       = '0;
    rd_en         = 1'b0;
    rd_addr       = '0;
    alloc_restart = 1'b0;
    alloc_bump    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid && n_ok) begin
          wr_en         = 1'b1;
          wr_data       = {K_TERM, {DATA_W{1'b0}}, {AW{1'b0}}};
          alloc_restart = 1'b1;
        end
      end
      ST_EVAL: begin
        if (leaf) begin
          rd_en   = 1'b1;
          rd_addr = cur_k;
        end else begin
          wr_en      = 1'b1;
          wr_addr    = alloc_idx;
          wr_data    = {K_PEND, cur_n, cur_k};
          alloc_bump = 1'b1;
        end
      end
      ST_APPLY: begin
        if (ld_tag == K_PEND) begin
          wr_en      = 1'b1;
          wr_addr    = alloc_idx;
          wr_data    = {K_SUM, acc, ld_link};
          alloc_bump = 1'b1;
        end else if (ld_tag == K_SUM) begin
          rd_en   = 1'b1;
          rd_addr = ld_link;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cur_n <= '0;
      cur_k <= '0;
      acc   <= '0;
      res_q <= '0;
      err_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          if (n_ok) begin
            cur_n <= req_n;
            cur_k <= '0;
            state <= ST_EVAL;
          end else begin
            res_q <= '0;
            err_q <= 1'b1;
            state <= ST_RESP;
          end
        end
        ST_EVAL: begin
          if (leaf) begin
            acc   <= DATA_W'(1);
            state <= ST_APPLY;
          end else begin
            cur_k <= alloc_idx;
            cur_n <= cur_n - DATA_W'(1);
          end
        end
        ST_APPLY: begin
          case (ld_tag)
            K_PEND: begin
              cur_k <= alloc_idx;
              cur_n <= ld_val - DATA_W'(2);
              state <= ST_EVAL;
            end
            K_SUM:  acc <= acc + ld_val;
            K_TERM: begin
              res_q <= acc;
              err_q <= 1'b0;
              state <= ST_RESP;
            end
            default: begin
              res_q <= '0;
              err_q <= 1'b1;
              state <= ST_RESP;
            end
          endcase
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_rsp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_value) && $stable(rsp_err));

  assert_reject_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_n == '0 || req_n > DATA_W'(MAX_N))
    |=> rsp_valid && rsp_err);

  assert_err_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_value == '0);

  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_load_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_addr < alloc_idx);

endmodule

// File: rtl/fib_cont_engine.sv
module fib_cont_engine #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_n,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_value,
  output logic              rsp_err
);
  localparam int AW    = $clog2(DEPTH);
  localparam int REC_W = 2 + DATA_W + AW;
  localparam int MAX_N = fib_pkg::max_n_for(DEPTH, DATA_W);

  logic             wr_en, rd_en, alloc_restart, alloc_bump;
  logic [AW-1:0]    wr_addr, rd_addr, alloc_idx;
  logic [REC_W-1:0] wr_data, rd_data;

  fib_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MAX_N(MAX_N)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_n(req_n),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_value(rsp_value), .rsp_err(rsp_err),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .alloc_restart(alloc_restart), .alloc_bump(alloc_bump), .alloc_idx(alloc_idx)
  );

  fib_rec_store #(.REC_W(REC_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  fib_bump_alloc #(.DEPTH(DEPTH)) u_alloc (
    .clk(clk), .rst_n(rst_n),
    .restart(alloc_restart), .bump(alloc_bump), .next_idx(alloc_idx)
  );

endmodule

// File: tb/fib_cont_engine_test.sv
module fib_cont_engine_test;
  localparam int DATA_W = 16;
  localparam int MAXN   = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [DATA_W-1:0] req_n = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b0;
  logic [DATA_W-1:0] rsp_value;
  logic              rsp_err;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  fib_cont_engine #(.DATA_W(DATA_W), .DEPTH(256)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_n(req_n),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_value(rsp_value), .rsp_err(rsp_err)
  );

  function automatic int ref_fib(input int n);
    int a = 1, b = 1;
    for (int i = 3; i <= n; i++) begin
      int t = a + b;
      a = b;
      b = t;
    end
    return b;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Offer n, wait for a result, consume it; returns value and error.
  task automatic run_one(input int n, output int val, output int err);
    @(negedge clk);
    req_valid = 1'b1;
    req_n     = DATA_W'(n);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 20000 && !rsp_valid; i++) @(negedge clk);
    val = int'(rsp_value);
    err = int'(rsp_err);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 req_ready", int'(req_ready), 1);
    check("R1 rsp_valid", int'(rsp_valid), 0);
  endtask

  task automatic t_base;
    int v, e;
    for (int n = 1; n <= 2; n++) begin
      run_one(n, v, e);
      check("R3 value", v, 1);
      check("R3 err", e, 0);
    end
  endtask

  task automatic t_range;
    int v, e;
    for (int n = 3; n <= MAXN; n++) begin
      run_one(n, v, e);
      check("R4 value", v, ref_fib(n));
      check("R4 err", e, 0);
    end
    check("R8 top value", v, 89);
  endtask

  task automatic t_reject;
    int bad [3] = '{0, MAXN + 1, 500};
    foreach (bad[i]) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_n     = DATA_W'(bad[i]);
      @(negedge clk);
      req_valid = 1'b0;
      check("R5 valid next cycle", int'(rsp_valid), 1);
      check("R5 err", int'(rsp_err), 1);
      check("R5 value", int'(rsp_value), 0);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
    end
    check("R8 n=12 rejected path done", int'(req_ready), 1);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    req_valid = 1'b1;
    req_n     = DATA_W'(7);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 20000 && !rsp_valid; i++) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R6 held valid", int'(rsp_valid), 1);
      check("R6 held value", int'(rsp_value), 13);
      check("R6 busy", int'(req_ready), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R6 consumed", int'(rsp_valid), 0);
    check("R6 idle again", int'(req_ready), 1);
  endtask

  task automatic t_busy_ignore;
    int v;
    @(negedge clk);
    req_valid = 1'b1;
    req_n     = DATA_W'(10);
    @(negedge clk);
    req_n = DATA_W'(3);
    for (int i = 0; i < 20; i++) begin
      check("R2 not ready while busy", int'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    for (int i = 0; i < 20000 && !rsp_valid; i++) @(negedge clk);
    v = int'(rsp_value);
    check("R2 busy input ignored", v, 55);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic t_repeat;
    int v, e;
    run_one(MAXN, v, e);
    check("R7 first large run", v, 89);
    run_one(MAXN, v, e);
    check("R7 second large run", v, 89);
    run_one(4, v, e);
    check("R7 small after large", v, 3);
    check("R9 result err", e, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        t_reset();
        t_base();
        t_range();
        t_reject();
        t_backpressure();
        t_busy_ignore();
        t_repeat();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule